// File: doc/BRIEF.md
# Keyed Service Watchdog

This block guards a processor against a hung program. Once it is enabled, it counts clock cycles. If software does not service it before a selectable timeout expires, it raises a one-cycle reset request. Servicing is deliberately awkward, so that a runaway program cannot do it by accident. Software must first write an arming key byte to one service register, and later write a clearing key byte to the same register. Only the clearing write that follows an arming write restarts the count.

The enable bit and a 2-bit timeout selector are captured once, on the first clock after reset is released. After that they are frozen until the next reset. The block watches an ordinary register write bus made of a strobe, an address and a byte. It reports whether a service sequence is currently half done (the armed flag) and issues the reset request. Generating the actual system reset from that request is left to the surrounding logic.

Top module: `wdog_top`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `rstReq` and `armed` are 0.
- R2: When the watchdog is enabled, a write of 0x55 to the service address (default 0x103A) sets `armed` on the clock edge that takes the write.
- R3: A write of 0xAA to the service address while `armed` is 1 clears `armed` and restarts the count. The next `rstReq` then arrives exactly one timeout period (2^(15+2·rate) cycles by default) after the edge that took the write.
- R4: A write of 0xAA to the service address while `armed` is 0 has no effect. `armed` stays 0 and the first timeout keeps its original timing.
- R5: Writes of any other byte to the service address, and writes of any byte to any other address, leave `armed` unchanged. Such writes may sit between the two keys without breaking the sequence. A repeated 0x55 while armed keeps `armed` at 1.
- R6: The timeout is 2^(BASE_LOG+2·rate) cycles, where rate is `cfgRate` (0 to 3) sampled on the first clock edge after reset release. With no servicing, `rstReq` goes high on edge number 2^(BASE_LOG+2·rate)+1, counting the first edge after release as 1.
- R7: `rstReq` is high for exactly one cycle. On that same edge `armed` clears and the count restarts, so an unserviced watchdog pulses again every 2^(BASE_LOG+2·rate) cycles.
- R8: If `cfgDisableN` is 0 when it is sampled, the watchdog is off until the next reset. `rstReq` never rises and key writes leave `armed` at 0. Changes to `cfgDisableN` or `cfgRate` after sampling have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgDisableN | input | 1 | Enable bit sampled at initialisation: 0 disables the watchdog |
| cfgRate | input | 2 | Timeout selector sampled at initialisation |
| wrEn | input | 1 | Register-bus write strobe |
| wrAddr | input | ADDR_W (16) | Register-bus write address |
| wrData | input | 8 | Register-bus write byte |
| rstReq | output | 1 | One-cycle reset request on timeout |
| armed | output | 1 | Status flag: arming key seen, clearing key awaited |

## Verification
The checker tests, on every cycle, the rules that are local in time. These are: that the reset request lasts one cycle, that the armed flag is clear when the request fires, and that the armed flag only rises after an arming write and only falls after a clearing write or a timeout. A stray clearing key while unarmed must leave the flag low. The length of each timeout period depends on the rate captured at initialisation and on where servicing happened, so only the bench shows it. The bench sweeps every rate, measures the edge on which each pulse occurs, and compares it with the power-of-two period. The disabled mode, the freezing of the configuration after capture, and sequences with interleaved bus writes are also shown only by bench scenarios.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int RATE_W = 2;
  localparam int RATES = 1 << RATE_W;
  localparam logic [7:0] KEY_ARM = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  // Strobes from the control side to the counter datapath
  typedef struct packed {
    logic run;                 // watchdog enabled and initialised
    logic restart;             // completed service pair this cycle
    logic [RATE_W-1:0] rate;   // frozen timeout selector
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h103A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDisableN,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              expire,
  output wdStrobe_t         strobe,
  output logic              armed
);
  logic loaded;
  logic enabled;
  logic [RATE_W-1:0] rateQ;
  logic svcHit;
  logic armKey;
  logic fireKey;

  assign svcHit  = wrEn && (wrAddr == SVC_ADDR);
  assign armKey  = svcHit && (wrData == KEY_ARM);
  assign fireKey = svcHit && (wrData == KEY_FIRE);

  assign strobe.run     = loaded && enabled;
  assign strobe.restart = loaded && enabled && armed && fireKey;
  assign strobe.rate    = rateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loaded  <= 1'b0;
      enabled <= 1'b0;
      rateQ   <= '0;
      armed   <= 1'b0;
    end else begin
      if (!loaded) begin
        loaded  <= 1'b1;
        enabled <= cfgDisableN;
        rateQ   <= cfgRate;
      end
      if (expire) begin
        armed <= 1'b0;
      end else if (strobe.restart) begin
        armed <= 1'b0;
      end else if (strobe.run && armKey) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int BASE_LOG = 15,
  parameter int STEP_LOG = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdStrobe_t  strobe,
  output logic       expire,
  output logic       rstReq
);
  localparam int CNT_W = BASE_LOG + STEP_LOG * (RATES - 1);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal [RATES];

  for (genvar g = 0; g < RATES; g++) begin : g_last
    localparam int LG = BASE_LOG + STEP_LOG * g;
    assign lastVal[g] = ALL_ONES >> (CNT_W - LG);
  end

  assign expire = strobe.run && !strobe.restart && (cnt == lastVal[strobe.rate]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= expire;
      if (!strobe.run || strobe.restart || expire) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h103A,
  parameter int BASE_LOG = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgDisableN,
  input  logic [1:0]        cfgRate,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              rstReq,
  output logic              armed
);
  wdStrobe_t strobe;
  logic expire;

  wdog_ctrl #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgDisableN(cfgDisableN), .cfgRate(cfgRate),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .expire(expire),
    .strobe(strobe), .armed(armed)
  );

  wdog_dp #(.BASE_LOG(BASE_LOG), .STEP_LOG(2)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .expire(expire), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = 16'h103A
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              rstReq,
  input logic              armed
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R7
  disarm_on_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> !armed);

  // R2
  arm_needs_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(wrEn && wrAddr == SVC_ADDR && wrData == 8'h55));

  // R3
  disarm_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(armed) |-> ($past(wrEn && wrAddr == SVC_ADDR && wrData == 8'hAA) || rstReq));

  // R4
  stray_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && wrEn && wrAddr == SVC_ADDR && wrData == 8'hAA) |=> !armed);
endmodule

bind wdog_top wdog_chk #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .rstReq(rstReq), .armed(armed)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
  localparam int BASE = 4;
  localparam logic [15:0] SVC = 16'h103A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgDisableN = 1'b1;
  logic [1:0] cfgRate = 2'd0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = 16'h0;
  logic [7:0] wrData = 8'h0;
  logic rstReq;
  logic armed;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int relCyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_top #(.BASE_LOG(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .cfgDisableN(cfgDisableN), .cfgRate(cfgRate),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rstReq(rstReq), .armed(armed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int limitOf(input int r);
    return 1 << (BASE + 2 * r);
  endfunction

  task automatic doReset(input bit en, input logic [1:0] r);
    @(negedge clk);
    rstN = 1'b0;
    cfgDisableN = en;
    cfgRate = r;
    repeat (3) @(negedge clk);
    check(rstReq == 1'b0 && armed == 1'b0, "R1 in reset", {rstReq, armed}, 0);
    rstN = 1'b1;
    relCyc = cyc;
    @(negedge clk);
    check(rstReq == 1'b0 && armed == 1'b0, "R1 after release", {rstReq, armed}, 0);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrAddr = a;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // returns edge index (cyc) at which rstReq is first seen high, or -1
  task automatic waitPulse(input int maxEdges, output int at);
    at = -1;
    for (int i = 0; i < maxEdges; i++) begin
      if (rstReq) begin
        at = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int at;
    int svcEdge;
    // R6, R7: sweep all rates without servicing
    for (int r = 0; r < 4; r++) begin
      doReset(1'b1, r[1:0]);
      waitPulse(5000, at);
      check(at - relCyc == limitOf(r) + 1, "R6 first timeout edge", at - relCyc, limitOf(r) + 1);
      check(armed == 1'b0, "R7 armed clear at pulse", armed, 0);
      @(negedge clk);
      check(rstReq == 1'b0, "R7 single-cycle pulse", rstReq, 0);
      svcEdge = at;
      waitPulse(5000, at);
      check(at - svcEdge == limitOf(r), "R7 repeat period", at - svcEdge, limitOf(r));
    end

    // R2, R5, R3: armed sequence with interleaved writes, rate 1
    doReset(1'b1, 2'd1);
    repeat (3) @(negedge clk);
    busWrite(SVC, 8'h55);
    check(armed == 1'b1, "R2 arm key sets armed", armed, 1);
    busWrite(SVC, 8'h12);
    busWrite(16'h1000, 8'hAA);
    busWrite(16'h103B, 8'hAA);
    busWrite(SVC, 8'h55);
    check(armed == 1'b1, "R5 other writes keep armed", armed, 1);
    busWrite(SVC, 8'hAA);
    svcEdge = cyc;
    check(armed == 1'b0, "R3 fire key disarms", armed, 0);
    waitPulse(5000, at);
    check(at - svcEdge == limitOf(1), "R3 restart period", at - svcEdge, limitOf(1));

    // R5: other value at service address while not armed leaves it low
    doReset(1'b1, 2'd1);
    busWrite(SVC, 8'h54);
    check(armed == 1'b0, "R5 wrong byte does not arm", armed, 0);
    busWrite(16'h003A, 8'h55);
    check(armed == 1'b0, "R5 wrong address does not arm", armed, 0);

    // R4: fire key while not armed, timing unchanged
    doReset(1'b1, 2'd1);
    repeat (3) @(negedge clk);
    busWrite(SVC, 8'hAA);
    check(armed == 1'b0, "R4 stray fire key", armed, 0);
    waitPulse(5000, at);
    check(at - relCyc == limitOf(1) + 1, "R4 timeout unchanged", at - relCyc, limitOf(1) + 1);

    // R8: disabled, long wait and keys have no effect
    doReset(1'b0, 2'd0);
    busWrite(SVC, 8'h55);
    check(armed == 1'b0, "R8 disabled ignores arm key", armed, 0);
    cfgDisableN = 1'b1;
    waitPulse(1200, at);
    check(at == -1, "R8 disabled never pulses", at, -1);

    // R8: configuration frozen after capture
    doReset(1'b1, 2'd0);
    cfgRate = 2'd3;
    cfgDisableN = 1'b0;
    waitPulse(5000, at);
    check(at - relCyc == limitOf(0) + 1, "R8 config frozen", at - relCyc, limitOf(0) + 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule